// File: doc/BRIEF.md
# Composite Video Sync Timing Generator

This block produces the raster timing for a low-resolution composite video display. A horizontal position counter steps once per enabled system clock and wraps at the end of each line. A vertical line counter advances only when the horizontal counter wraps. Around each counter sits a small phase state machine. From these the block drives active-low horizontal, vertical and composite sync pins, the current pixel and line numbers, and an active-video flag that a pixel pipeline uses to decide when to shift out picture data.

Two inputs choose the frame geometry and the composite sync rule. The geometry input selects a 50 Hz frame (312 lines of 1024 clocks at 16 MHz) or a 60 Hz frame (262 lines of 1016 clocks). The rule input selects how horizontal and vertical sync are merged. Both inputs are sampled at reset and otherwise only at the frame wrap, so a change never produces a broken frame.

The horizontal phase machine has the states H_IDLE, H_SYNC, H_BACK, H_ACT and H_FRONT. On the first enabled clock it moves from H_IDLE to H_SYNC. It then moves from H_SYNC to H_BACK at the end of the sync pulse, from H_BACK to H_ACT at the start of the picture, and from H_ACT to H_FRONT at the end of the picture. From any running state it returns to H_SYNC at the line wrap. The vertical phase machine has the states V_IDLE, V_ACT, V_FRONT, V_SYNC and V_BACK. It moves from V_IDLE to V_ACT on the first enabled clock. It then moves from V_ACT to V_FRONT after the last picture line, from V_FRONT to V_SYNC at the sync start line, and from V_SYNC to V_BACK after the sync lines. From any running state it returns to V_ACT at the frame wrap.

Top module: `csync_timing_gen`

## Requirements
- R1: While rst is high, and after it falls until the first clock with clk_en high, hsync_n, vsync_n and csync_n are 1, active_o is 0, and pix_x and line_y are 0.
- R2: A clock with clk_en low changes no output.
- R3: pix_x runs 0 to L-1 and then returns to 0, one step per enabled clock. With std_sel_i = 0, L is 1024. With std_sel_i = 1, L is 1016.
- R4: hsync_n is low exactly while pix_x is below 75, on every line. Its falling edge always coincides with pix_x = 0.
- R5: line_y increments only when pix_x wraps. It runs 0 to 311 when std_sel_i = 0 and 0 to 261 when std_sel_i = 1, then returns to 0.
- R6: vsync_n is low for exactly 3 lines per frame, starting at line 272 when std_sel_i = 0 and at line 232 when std_sel_i = 1.
- R7: With csync_mode_i = 2'b00, or the spare code 2'b11, csync_n is low whenever hsync_n or vsync_n is low.
- R8: With csync_mode_i = 2'b01, csync_n equals NOT(hsync_n XOR vsync_n). It follows hsync_n outside vertical sync and is its inverse during vertical sync.
- R9: With csync_mode_i = 2'b10, csync_n equals hsync_n and ignores vertical sync.
- R10: active_o is high exactly when pix_x is at least 200 and below 904, and line_y is below 184.
- R11: std_sel_i and csync_mode_i take effect at reset and at the frame wrap (last pixel of the last line), never mid-frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Advances the raster by one position when high |
| std_sel_i | input | 1 | Frame geometry: 0 = 312-line 50 Hz, 1 = 262-line 60 Hz |
| csync_mode_i | input | 2 | Composite rule: 00 OR, 01 XNOR, 10 horizontal only, 11 OR |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| csync_n | output | 1 | Composite sync, active low |
| pix_x | output | HW | Position within the line in clocks |
| line_y | output | VW | Line number within the frame |
| active_o | output | 1 | High inside the visible picture window |

## Verification
The bench builds the block with 24-clock and 20-clock lines, 12-line and 10-line frames, a 3-clock horizontal sync, a 6 to 15 picture window over 4 lines, and vertical sync at line 8 or 6. With these values a whole frame takes a few hundred clocks. Many frame wraps, geometry switches in both directions, every composite rule across vertical sync, and thinned clock enables all fit in a short run. A reference raster model in the bench is compared every clock, and directed steps cover reset, a mid-frame geometry change and a held enable.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic {
        STD_50HZ = 1'b0,
        STD_60HZ = 1'b1
    } std_e;

    typedef enum logic [1:0] {
        CS_OR    = 2'b00,
        CS_XNOR  = 2'b01,
        CS_HONLY = 2'b10,
        CS_OR2   = 2'b11
    } csmode_e;

    typedef enum logic [2:0] {
        H_IDLE,
        H_SYNC,
        H_BACK,
        H_ACT,
        H_FRONT
    } h_state_e;

    typedef enum logic [2:0] {
        V_IDLE,
        V_ACT,
        V_FRONT,
        V_SYNC,
        V_BACK
    } v_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/csg_line_fsm.sv
module csg_line_fsm
    import csg_pkg::*;
#(
    parameter int H_TOTAL_A = 1024,
    parameter int H_TOTAL_B = 1016,
    parameter int HS_CLKS   = 75,
    parameter int ACT_START = 200,
    parameter int ACT_CLKS  = 704,
    parameter int HW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  std_e          geo_std,
    output logic [HW-1:0] h_cnt,
    output logic          line_wrap,
    output logic          hsync_n,
    output logic          h_act
);

    localparam logic [HW-1:0] LAST_A  = HW'(H_TOTAL_A - 1);
    localparam logic [HW-1:0] LAST_B  = HW'(H_TOTAL_B - 1);
    localparam logic [HW-1:0] HS_END  = HW'(HS_CLKS);
    localparam logic [HW-1:0] ACT_BEG = HW'(ACT_START);
    localparam logic [HW-1:0] ACT_END = HW'(ACT_START + ACT_CLKS);

    h_state_e      st_q, st_d;
    logic [HW-1:0] h_q, h_d, h_inc, last;
    logic          wrap;

    assign h_inc = h_q + 1'b1;
    assign last  = (geo_std == STD_60HZ) ? LAST_B : LAST_A;

    // next state and next position
    always_comb begin
        st_d = st_q;
        h_d  = h_q;
        wrap = 1'b0;
        if (clk_en) begin
            if (st_q == H_IDLE) begin
                st_d = H_SYNC;
                h_d  = '0;
            end else if (h_q == last) begin
                st_d = H_SYNC;
                h_d  = '0;
                wrap = 1'b1;
            end else begin
                h_d = h_inc;
                unique case (st_q)
                    H_SYNC:  if (h_inc == HS_END)  st_d = H_BACK;
                    H_BACK:  if (h_inc == ACT_BEG) st_d = H_ACT;
                    H_ACT:   if (h_inc == ACT_END) st_d = H_FRONT;
                    default: st_d = st_q;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= H_IDLE;
            h_q  <= '0;
        end else begin
            st_q <= st_d;
            h_q  <= h_d;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        hsync_n   = (st_q != H_SYNC);
        h_act     = (st_q == H_ACT);
        h_cnt     = h_q;
        line_wrap = wrap;
    end

endmodule

// File: rtl/csg_frame_fsm.sv
module csg_frame_fsm
    import csg_pkg::*;
#(
    parameter int LINES_A   = 312,
    parameter int LINES_B   = 262,
    parameter int ACT_LINES = 184,
    parameter int VS_LINE_A = 272,
    parameter int VS_LINE_B = 232,
    parameter int VS_LINES  = 3,
    parameter int VW        = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          line_wrap,
    input  std_e          geo_std,
    output logic [VW-1:0] v_cnt,
    output logic          frame_wrap,
    output logic          vsync_n,
    output logic          v_act
);

    localparam logic [VW-1:0] LAST_A = VW'(LINES_A - 1);
    localparam logic [VW-1:0] LAST_B = VW'(LINES_B - 1);
    localparam logic [VW-1:0] VA_END = VW'(ACT_LINES);
    localparam logic [VW-1:0] VS_A   = VW'(VS_LINE_A);
    localparam logic [VW-1:0] VS_B   = VW'(VS_LINE_B);
    localparam logic [VW-1:0] VE_A   = VW'(VS_LINE_A + VS_LINES);
    localparam logic [VW-1:0] VE_B   = VW'(VS_LINE_B + VS_LINES);

    v_state_e      st_q, st_d;
    logic [VW-1:0] v_q, v_d, v_inc, last, vs_beg, vs_end;
    logic          wrap;

    assign v_inc  = v_q + 1'b1;
    assign last   = (geo_std == STD_60HZ) ? LAST_B : LAST_A;
    assign vs_beg = (geo_std == STD_60HZ) ? VS_B : VS_A;
    assign vs_end = (geo_std == STD_60HZ) ? VE_B : VE_A;

    // next state and next line
    always_comb begin
        st_d = st_q;
        v_d  = v_q;
        wrap = 1'b0;
        if (st_q == V_IDLE) begin
            if (clk_en) begin
                st_d = V_ACT;
                v_d  = '0;
            end
        end else if (line_wrap) begin
            if (v_q == last) begin
                st_d = V_ACT;
                v_d  = '0;
                wrap = 1'b1;
            end else begin
                v_d = v_inc;
                unique case (st_q)
                    V_ACT:   if (v_inc == VA_END) st_d = V_FRONT;
                    V_FRONT: if (v_inc == vs_beg) st_d = V_SYNC;
                    V_SYNC:  if (v_inc == vs_end) st_d = V_BACK;
                    default: st_d = st_q;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= V_IDLE;
            v_q  <= '0;
        end else begin
            st_q <= st_d;
            v_q  <= v_d;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        vsync_n    = (st_q != V_SYNC);
        v_act      = (st_q == V_ACT);
        v_cnt      = v_q;
        frame_wrap = wrap;
    end

endmodule

// File: rtl/csg_sync_mix.sv
module csg_sync_mix
    import csg_pkg::*;
(
    input  logic    hsync_n,
    input  logic    vsync_n,
    input  csmode_e mode,
    output logic    csync_n
);

    always_comb begin
        unique case (mode)
            CS_XNOR:  csync_n = ~(hsync_n ^ vsync_n);
            CS_HONLY: csync_n = hsync_n;
            default:  csync_n = hsync_n & vsync_n;
        endcase
    end

endmodule

// File: rtl/csync_timing_gen.sv
module csync_timing_gen
    import csg_pkg::*;
#(
    parameter int H_TOTAL_PAL  = 1024,
    parameter int H_TOTAL_NTSC = 1016,
    parameter int HSYNC_CLKS   = 75,
    parameter int ACT_H_START  = 200,
    parameter int ACT_H_CLKS   = 704,
    parameter int LINES_PAL    = 312,
    parameter int LINES_NTSC   = 262,
    parameter int ACT_LINES    = 184,
    parameter int VSYNC_AT_PAL = 272,
    parameter int VSYNC_AT_NTSC = 232,
    parameter int VSYNC_LINES  = 3,
    localparam int HW = $clog2(imax(H_TOTAL_PAL, H_TOTAL_NTSC)),
    localparam int VW = $clog2(imax(LINES_PAL, LINES_NTSC))
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          std_sel_i,
    input  logic [1:0]    csync_mode_i,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          csync_n,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] line_y,
    output logic          active_o
);

    std_e    geo_std;
    csmode_e geo_mode;
    logic    line_wrap, frame_wrap, h_act, v_act;

    // geometry and sync rule are sampled only at reset and frame wrap
    always_ff @(posedge clk) begin
        if (rst || frame_wrap) begin
            geo_std  <= std_e'(std_sel_i);
            geo_mode <= csmode_e'(csync_mode_i);
        end
    end

    csg_line_fsm #(
        .H_TOTAL_A (H_TOTAL_PAL),
        .H_TOTAL_B (H_TOTAL_NTSC),
        .HS_CLKS   (HSYNC_CLKS),
        .ACT_START (ACT_H_START),
        .ACT_CLKS  (ACT_H_CLKS),
        .HW        (HW)
    ) u_line (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .geo_std   (geo_std),
        .h_cnt     (pix_x),
        .line_wrap (line_wrap),
        .hsync_n   (hsync_n),
        .h_act     (h_act)
    );

    csg_frame_fsm #(
        .LINES_A   (LINES_PAL),
        .LINES_B   (LINES_NTSC),
        .ACT_LINES (ACT_LINES),
        .VS_LINE_A (VSYNC_AT_PAL),
        .VS_LINE_B (VSYNC_AT_NTSC),
        .VS_LINES  (VSYNC_LINES),
        .VW        (VW)
    ) u_frame (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .line_wrap  (line_wrap),
        .geo_std    (geo_std),
        .v_cnt      (line_y),
        .frame_wrap (frame_wrap),
        .vsync_n    (vsync_n),
        .v_act      (v_act)
    );

    csg_sync_mix u_mix (
        .hsync_n (hsync_n),
        .vsync_n (vsync_n),
        .mode    (geo_mode),
        .csync_n (csync_n)
    );

    assign active_o = h_act & v_act;

endmodule

// File: rtl/csg_chk.sv
module csg_chk #(
    parameter int HW      = 10,
    parameter int VW      = 9,
    parameter int HS_LEN  = 75,
    parameter int H_SHORT = 1016,
    parameter int VS_LO   = 232,
    parameter int VS_HI   = 275
) (
    input logic          clk,
    input logic          rst,
    input logic          clk_en,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          csync_n,
    input logic [HW-1:0] pix_x,
    input logic [VW-1:0] line_y,
    input logic          active_o
);

    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        rst_q |-> (hsync_n && vsync_n && csync_n && !active_o && pix_x == '0 && line_y == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(pix_x) && $stable(line_y) && $stable(hsync_n) && $stable(vsync_n)));

    // R3
    pix_step_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_en && pix_x != '0 && int'(pix_x) < H_SHORT - 1) |=> (pix_x == $past(pix_x) + 1'b1));

    // R4
    hs_width_chk: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> (int'(pix_x) < HS_LEN));

    // R4
    hs_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |-> (pix_x == '0));

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_y) |-> (pix_x == '0));

    // R6
    vs_window_chk: assert property (@(posedge clk) disable iff (rst)
        !vsync_n |-> (int'(line_y) >= VS_LO && int'(line_y) < VS_HI));

    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (hsync_n && vsync_n) |-> csync_n);

    // R8
    cs_hpulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!hsync_n && vsync_n) |-> !csync_n);

    // R10
    act_blank_chk: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (hsync_n && vsync_n));

endmodule

bind csync_timing_gen csg_chk #(
    .HW      (HW),
    .VW      (VW),
    .HS_LEN  (HSYNC_CLKS),
    .H_SHORT (csg_pkg::imin(H_TOTAL_PAL, H_TOTAL_NTSC)),
    .VS_LO   (csg_pkg::imin(VSYNC_AT_PAL, VSYNC_AT_NTSC)),
    .VS_HI   (csg_pkg::imax(VSYNC_AT_PAL, VSYNC_AT_NTSC) + VSYNC_LINES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .csync_n  (csync_n),
    .pix_x    (pix_x),
    .line_y   (line_y),
    .active_o (active_o)
);

// File: tb/csync_timing_gen_tb.sv
module csync_timing_gen_tb;

    localparam int HP  = 24;
    localparam int HN  = 20;
    localparam int HS  = 3;
    localparam int AS  = 6;
    localparam int AL  = 10;
    localparam int LP  = 12;
    localparam int LN  = 10;
    localparam int VA  = 4;
    localparam int VSP = 8;
    localparam int VSN = 6;
    localparam int VSL = 3;
    localparam int HW  = 5;
    localparam int VW  = 4;

    typedef struct packed {
        logic        std;
        logic [1:0]  mode;
        logic [1:0]  en_pat;
        logic [11:0] cycles;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 2'd0, 2'd0, 12'd700},
        '{1'b1, 2'd1, 2'd0, 12'd700},
        '{1'b1, 2'd2, 2'd1, 12'd500},
        '{1'b0, 2'd3, 2'd2, 12'd900},
        '{1'b0, 2'd1, 2'd0, 12'd600},
        '{1'b1, 2'd0, 2'd1, 12'd500}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b0;
    logic          std_sel = 1'b0;
    logic [1:0]    cs_mode = 2'd0;
    logic          hsync_n, vsync_n, csync_n, active_o;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] line_y;

    int vec_n = 0;
    int bad_n = 0;

    bit       m_run = 1'b0;
    int       m_h = 0;
    int       m_v = 0;
    bit       m_std = 1'b0;
    bit [1:0] m_mode = 2'd0;

    always #10 clk = ~clk;

    csync_timing_gen #(
        .H_TOTAL_PAL (HP), .H_TOTAL_NTSC (HN), .HSYNC_CLKS (HS),
        .ACT_H_START (AS), .ACT_H_CLKS (AL),
        .LINES_PAL (LP), .LINES_NTSC (LN), .ACT_LINES (VA),
        .VSYNC_AT_PAL (VSP), .VSYNC_AT_NTSC (VSN), .VSYNC_LINES (VSL)
    ) u_dut (
        .clk (clk), .rst (rst), .clk_en (clk_en),
        .std_sel_i (std_sel), .csync_mode_i (cs_mode),
        .hsync_n (hsync_n), .vsync_n (vsync_n), .csync_n (csync_n),
        .pix_x (pix_x), .line_y (line_y), .active_o (active_o)
    );

    function automatic int len_of(bit s);   return s ? HN : HP;   endfunction
    function automatic int lines_of(bit s); return s ? LN : LP;   endfunction
    function automatic int vs_of(bit s);    return s ? VSN : VSP; endfunction

    // raster model built from R1, R3, R5 and R11
    task automatic model_edge();
        if (rst) begin
            m_run = 1'b0; m_h = 0; m_v = 0; m_std = std_sel; m_mode = cs_mode;
        end else if (clk_en) begin
            if (!m_run) begin
                m_run = 1'b1; m_h = 0; m_v = 0;
            end else if (m_h == len_of(m_std) - 1) begin
                m_h = 0;
                if (m_v == lines_of(m_std) - 1) begin
                    m_v = 0; m_std = std_sel; m_mode = cs_mode;
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
    endtask

    task automatic compare(string tag);
        bit hs_e, vs_e, cs_e, act_e, ok;
        string cs_req;
        hs_e  = !(m_run && m_h < HS);
        vs_e  = !(m_run && m_v >= vs_of(m_std) && m_v < vs_of(m_std) + VSL);
        act_e = m_run && m_h >= AS && m_h < AS + AL && m_v < VA;
        case (m_mode)
            2'd1:    begin cs_e = !(hs_e ^ vs_e); cs_req = "R8"; end
            2'd2:    begin cs_e = hs_e;           cs_req = "R9"; end
            default: begin cs_e = hs_e & vs_e;    cs_req = "R7"; end
        endcase
        ok = 1'b1;
        vec_n++;
        if (int'(pix_x) != m_h) begin
            ok = 0; $display("FAIL %s R3 pix_x got %0d exp %0d", tag, pix_x, m_h);
        end
        if (int'(line_y) != m_v) begin
            ok = 0; $display("FAIL %s R5 line_y got %0d exp %0d", tag, line_y, m_v);
        end
        if (hsync_n !== hs_e) begin
            ok = 0; $display("FAIL %s R4 hsync_n got %b exp %b", tag, hsync_n, hs_e);
        end
        if (vsync_n !== vs_e) begin
            ok = 0; $display("FAIL %s R6 vsync_n got %b exp %b", tag, vsync_n, vs_e);
        end
        if (csync_n !== cs_e) begin
            ok = 0; $display("FAIL %s %s csync_n got %b exp %b", tag, cs_req, csync_n, cs_e);
        end
        if (active_o !== act_e) begin
            ok = 0; $display("FAIL %s R10 active_o got %b exp %b", tag, active_o, act_e);
        end
        if (!ok) bad_n++;
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic check_flag(string tag, bit got, bit exp);
        vec_n++;
        if (got !== exp) begin
            bad_n++;
            $display("FAIL %s got %b exp %b", tag, got, exp);
        end
    endtask

    initial begin
        int max_line;
        bit seen_hi;

        // R1: reset state with clk_en held high
        rst = 1'b1; clk_en = 1'b1;
        for (int i = 0; i < 3; i++) cyc("R1 reset");
        rst = 1'b0; clk_en = 1'b0;

        // R2 and R1: no progress while clk_en is low after reset
        for (int i = 0; i < 5; i++) cyc("R2 hold");

        // table walk (R3 to R11)
        for (int i = 0; i < 6; i++) begin
            std_sel = VECS[i].std;
            cs_mode = VECS[i].mode;
            for (int c = 0; c < int'(VECS[i].cycles); c++) begin
                case (VECS[i].en_pat)
                    2'd1:    clk_en = (c % 2) == 0;
                    2'd2:    clk_en = (c % 3) == 0;
                    default: clk_en = 1'b1;
                endcase
                cyc("table");
            end
        end

        // R2: enable low mid-line keeps every output still
        clk_en = 1'b0;
        for (int i = 0; i < 7; i++) cyc("R2 mid-line hold");

        // R11: geometry change mid-frame waits for the wrap
        rst = 1'b1; std_sel = 1'b0; cs_mode = 2'd0; clk_en = 1'b1;
        cyc("R1 re-reset");
        rst = 1'b0;
        for (int i = 0; i < 5 * HP + 2; i++) cyc("R11 lead");
        std_sel = 1'b1;
        seen_hi = 1'b0;
        for (int i = 0; i < 8 * HP; i++) begin
            cyc("R11 old frame");
            if (int'(line_y) == LP - 1) seen_hi = 1'b1;
        end
        check_flag("R11 line 11 reached before wrap", seen_hi, 1'b1);
        for (int i = 0; i < 2 * HP; i++) cyc("R11 wrap");
        max_line = 0;
        for (int i = 0; i < LN * HN; i++) begin
            cyc("R11 new frame");
            if (int'(line_y) > max_line) max_line = int'(line_y);
        end
        check_flag("R5 new frame stops at line 9", max_line == LN - 1, 1'b1);

        // R1: reset in the middle of a line
        rst = 1'b1;
        cyc("R1 mid-run reset");
        check_flag("R1 hsync_n high in reset", hsync_n, 1'b1);
        check_flag("R1 csync_n high in reset", csync_n, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad_n++;
        $display("FAIL watchdog R3 cycles got 200000 exp fewer");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule